// File: doc/BRIEF.md
# Sixteen-Channel Trigger Qualifier for a Waveform Sampler

This block decides, channel by channel, when a self-triggered waveform sampler should stop writing its circular analog memory. Each channel watches one of three trigger sources, chosen by its mode word:
- its own discriminator bit;
- a shared external trigger;
- a central trigger, which is the OR of the local-edge events of every enabled channel set to the local source.

The mode word also selects the active edge, enables or disables the channel, and sets a post-trigger delay of 0, 1 or 2 clock steps.

When a channel fires and its delay has run out, it stops sampling. It latches the 6-bit write-cell pointer of the 64-cell ring and the shared 12-bit Gray-coded coarse timestamp, then holds a conversion request. The channel ignores all further triggers until the conversion logic reports it free. A global enable input gates the acceptance of new triggers on all channels at once, so that the channels share one dead time.

Configuration is written one channel at a time through a 4-bit channel address and a 6-bit mode word.

Top module: `chan_trig_ctrl`

## Requirements
- R1: After reset every channel is sampling (`sample_run` all ones), no conversion request is raised, `central_trig` is low, and every mode word is zero, so every channel is disabled.
- R2: A write with `cfg_we` high stores `cfg_data` as the mode word of channel `cfg_addr` only. The mode word fields are:
  - bit 0: enable;
  - bit 1: edge select, 0 = rising, 1 = falling;
  - bits 3:2: source, 0 = own discriminator, 1 = external, 2 = central, 3 = none;
  - bits 5:4: post-trigger delay.
- R3: A channel set to its own discriminator fires only on the selected edge of `disc_in[ch]`. An edge of the opposite direction has no effect.
- R4: A channel set to the external source fires on the selected edge of `ext_trig`.
- R5: The central trigger is the OR of the selected-edge events of all channels that are enabled and set to their own discriminator. A channel set to the central source fires in the same cycle as that OR, whatever its edge bit says. `central_trig` shows the OR one cycle later.
- R6: A channel whose enable bit is 0 never fires.
- R7: While `glob_en` is low, no sampling channel accepts a trigger.
- R8: With post-trigger delay d, where a code of 3 acts as 2, the channel keeps sampling for d more clock edges after the triggering edge. It then captures `cell_ptr` and `ts_gray` as sampled on that final edge.
- R9: A channel in the held state keeps `conv_req` high and `sample_run` low, keeps its captured cell and timestamp stable, and ignores further triggers until `conv_free` is seen.
- R10: When `conv_free[ch]` is high during the held state, the channel returns to sampling on the next clock edge.
- R11: Source code 3 never fires a channel, whatever the discriminator or the external input do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_addr | input | 4 | Channel addressed by the write |
| cfg_data | input | 6 | Mode word to store |
| glob_en | input | 1 | Global trigger acceptance enable |
| disc_in | input | 16 | Per-channel discriminator bits |
| ext_trig | input | 1 | Shared external trigger |
| cell_ptr | input | 6 | Current write cell of the circular memory |
| ts_gray | input | 12 | Gray-coded coarse timestamp |
| conv_free | input | 16 | Per-channel release from the conversion logic |
| sample_run | output | 16 | Channel is still writing its memory |
| conv_req | output | 16 | Channel holds a capture and requests conversion |
| cap_cell | output | 96 | Captured cell index, 6 bits per channel, channel 0 in the low bits |
| cap_ts | output | 192 | Captured timestamp, 12 bits per channel, channel 0 in the low bits |
| central_trig | output | 1 | Registered copy of the central trigger OR |

## Verification
Random trials pick a channel, an edge and a delay code including the code 3. Each trial compares the captured pointer and timestamp with the counter value the bench predicts for the final edge. This separates an off-by-one delay from a correct one and shows that code 3 is treated as 2.

Directed patterns cover the rest:
- the opposite edge, to separate edge selection from plain level change;
- a disabled channel, a cleared global enable and source code 3, each of which must produce no capture;
- an external pulse;
- a local channel feeding a central-source channel, to tell the central OR apart from the channel's own input;
- toggling while held, to show that the captured values do not move until release.

// File: rtl/chan_trig_pkg.sv
package chan_trig_pkg;

  typedef enum logic [1:0] {
    SRC_LOCAL   = 2'd0,
    SRC_EXT     = 2'd1,
    SRC_CENTRAL = 2'd2,
    SRC_NONE    = 2'd3
  } src_e;

  // Mode word layout: bit 0 enable, bit 1 falling edge, bits 3:2 source,
  // bits 5:4 post-trigger delay code.
  typedef struct packed {
    logic [1:0] post;
    src_e       src;
    logic       fall;
    logic       en;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_HELD = 2'd2
  } chan_st_e;

endpackage

// File: rtl/chan_trig_cfg.sv
module chan_trig_cfg
  import chan_trig_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [MODE_W-1:0]        wdata,
  output logic [N_CH*MODE_W-1:0]   modes_flat
);

  logic [MODE_W-1:0] mode_q [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[i] <= '0;
      end else if (we && (addr == ADDR_W'(i))) begin
        mode_q[i] <= wdata;
      end
    end
    assign modes_flat[i*MODE_W +: MODE_W] = mode_q[i];
  end

endmodule

// File: rtl/chan_trig_edge.sv
module chan_trig_edge
  import chan_trig_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_CH-1:0]        disc_in,
  input  logic                   ext_trig,
  input  logic [N_CH*MODE_W-1:0] modes_flat,
  output logic [N_CH-1:0]        local_evt,
  output logic [N_CH-1:0]        ext_evt
);

  logic [N_CH-1:0] disc_q;
  logic            ext_q;
  logic [N_CH-1:0] disc_rise;
  logic [N_CH-1:0] disc_fall;
  logic            ext_rise;
  logic            ext_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      disc_q <= '0;
      ext_q  <= 1'b0;
    end else begin
      disc_q <= disc_in;
      ext_q  <= ext_trig;
    end
  end

  assign disc_rise = disc_in & ~disc_q;
  assign disc_fall = ~disc_in & disc_q;
  assign ext_rise  = ext_trig & ~ext_q;
  assign ext_fall  = ~ext_trig & ext_q;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    mode_t m;
    assign m            = mode_t'(modes_flat[i*MODE_W +: MODE_W]);
    assign local_evt[i] = m.fall ? disc_fall[i] : disc_rise[i];
    assign ext_evt[i]   = m.fall ? ext_fall : ext_rise;
  end

endmodule

// File: rtl/chan_trig_unit.sv
module chan_trig_unit
  import chan_trig_pkg::*;
#(
  parameter int CELL_W   = 6,
  parameter int TS_W     = 12,
  parameter int POST_MAX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_raw,
  input  logic              glob_en,
  input  logic              ev_local,
  input  logic              ev_ext,
  input  logic              ev_central,
  input  logic              conv_free,
  input  logic [CELL_W-1:0] cell_ptr,
  input  logic [TS_W-1:0]   ts_gray,
  output logic              run,
  output logic              req,
  output logic [CELL_W-1:0] cap_cell,
  output logic [TS_W-1:0]   cap_ts
);

  localparam int CNT_W = (POST_MAX < 2) ? 1 : $clog2(POST_MAX + 1);

  mode_t            mode;
  chan_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] post_eff;
  logic             src_hit;
  logic             fire;

  assign mode = mode_t'(mode_raw);

  always_comb begin
    case (mode.src)
      SRC_LOCAL:   src_hit = ev_local;
      SRC_EXT:     src_hit = ev_ext;
      SRC_CENTRAL: src_hit = ev_central;
      default:     src_hit = 1'b0;
    endcase
  end

  assign fire     = mode.en & glob_en & src_hit;
  assign post_eff = (int'(mode.post) > POST_MAX) ? CNT_W'(POST_MAX) : CNT_W'(mode.post);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      cnt_q    <= '0;
      cap_cell <= '0;
      cap_ts   <= '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (fire) begin
            if (post_eff == '0) begin
              cap_cell <= cell_ptr;
              cap_ts   <= ts_gray;
              st_q     <= ST_HELD;
            end else begin
              cnt_q <= post_eff;
              st_q  <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (cnt_q == CNT_W'(1)) begin
            cap_cell <= cell_ptr;
            cap_ts   <= ts_gray;
            st_q     <= ST_HELD;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_HELD: begin
          if (conv_free) st_q <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign run = (st_q != ST_HELD);
  assign req = (st_q == ST_HELD);

endmodule

// File: rtl/chan_trig_ctrl.sv
module chan_trig_ctrl
  import chan_trig_pkg::*;
#(
  parameter int N_CH     = 16,
  parameter int ADDR_W   = 4,
  parameter int CELL_W   = 6,
  parameter int TS_W     = 12,
  parameter int POST_MAX = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [5:0]             cfg_data,
  input  logic                   glob_en,
  input  logic [N_CH-1:0]        disc_in,
  input  logic                   ext_trig,
  input  logic [CELL_W-1:0]      cell_ptr,
  input  logic [TS_W-1:0]        ts_gray,
  input  logic [N_CH-1:0]        conv_free,
  output logic [N_CH-1:0]        sample_run,
  output logic [N_CH-1:0]        conv_req,
  output logic [N_CH*CELL_W-1:0] cap_cell,
  output logic [N_CH*TS_W-1:0]   cap_ts,
  output logic                   central_trig
);

  logic [N_CH*MODE_W-1:0] modes_flat;
  logic [N_CH-1:0]        local_evt;
  logic [N_CH-1:0]        ext_evt;
  logic [N_CH-1:0]        feeds_central;
  logic                   central_now;

  chan_trig_cfg #(.N_CH(N_CH), .ADDR_W(ADDR_W)) cfg_i (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (MODE_W'(cfg_data)),
    .modes_flat (modes_flat)
  );

  chan_trig_edge #(.N_CH(N_CH)) edge_i (
    .clk        (clk),
    .rst        (rst),
    .disc_in    (disc_in),
    .ext_trig   (ext_trig),
    .modes_flat (modes_flat),
    .local_evt  (local_evt),
    .ext_evt    (ext_evt)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_feed
    mode_t m;
    assign m                = mode_t'(modes_flat[i*MODE_W +: MODE_W]);
    assign feeds_central[i] = m.en & (m.src == SRC_LOCAL);
  end

  assign central_now = |(local_evt & feeds_central);

  always_ff @(posedge clk) begin
    if (rst) central_trig <= 1'b0;
    else     central_trig <= central_now;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_unit
    chan_trig_unit #(
      .CELL_W   (CELL_W),
      .TS_W     (TS_W),
      .POST_MAX (POST_MAX)
    ) unit_i (
      .clk        (clk),
      .rst        (rst),
      .mode_raw   (modes_flat[i*MODE_W +: MODE_W]),
      .glob_en    (glob_en),
      .ev_local   (local_evt[i]),
      .ev_ext     (ext_evt[i]),
      .ev_central (central_now),
      .conv_free  (conv_free[i]),
      .cell_ptr   (cell_ptr),
      .ts_gray    (ts_gray),
      .run        (sample_run[i]),
      .req        (conv_req[i]),
      .cap_cell   (cap_cell[i*CELL_W +: CELL_W]),
      .cap_ts     (cap_ts[i*TS_W +: TS_W])
    );
  end

endmodule

// File: rtl/chan_trig_ctrl_chk.sv
module chan_trig_ctrl_chk #(
  parameter int N_CH   = 16,
  parameter int CELL_W = 6,
  parameter int TS_W   = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_CH-1:0]        conv_free,
  input logic [N_CH-1:0]        sample_run,
  input logic [N_CH-1:0]        conv_req,
  input logic [N_CH*CELL_W-1:0] cap_cell,
  input logic [N_CH*TS_W-1:0]   cap_ts
);

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R9: a held channel without release stays held
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (conv_req[i] && !conv_free[i]) |=> conv_req[i]);

    // R9: captured values do not move while held
    p_cap_stable_r9: assert property (@(posedge clk) disable iff (rst)
      (conv_req[i] && $past(conv_req[i])) |->
        ($stable(cap_cell[i*CELL_W +: CELL_W]) && $stable(cap_ts[i*TS_W +: TS_W])));

    // R10: release returns the channel to sampling
    p_release_r10: assert property (@(posedge clk) disable iff (rst)
      (conv_req[i] && conv_free[i]) |=> (sample_run[i] && !conv_req[i]));

    // R9: sampling and conversion request never coincide
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
      sample_run[i] != conv_req[i]);
  end

endmodule

bind chan_trig_ctrl chan_trig_ctrl_chk #(
  .N_CH   (N_CH),
  .CELL_W (CELL_W),
  .TS_W   (TS_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .conv_free  (conv_free),
  .sample_run (sample_run),
  .conv_req   (conv_req),
  .cap_cell   (cap_cell),
  .cap_ts     (cap_ts)
);

// File: tb/chan_trig_ctrl_tb_top.sv
`timescale 1ns/1ps
module chan_trig_ctrl_tb_top;

  localparam int N_CH = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [3:0]        cfg_addr = '0;
  logic [5:0]        cfg_data = '0;
  logic              glob_en = 1'b1;
  logic [N_CH-1:0]   disc_in = '0;
  logic              ext_trig = 1'b0;
  logic [5:0]        cell_ptr;
  logic [11:0]       ts_gray;
  logic [N_CH-1:0]   conv_free = '0;
  logic [N_CH-1:0]   sample_run;
  logic [N_CH-1:0]   conv_req;
  logic [N_CH*6-1:0] cap_cell;
  logic [N_CH*12-1:0] cap_ts;
  logic              central_trig;

  int unsigned tb_cnt = 0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tb_cnt <= tb_cnt + 1;

  assign cell_ptr = tb_cnt[5:0];
  assign ts_gray  = tb_cnt[11:0] ^ (tb_cnt[11:0] >> 1);

  chan_trig_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .glob_en(glob_en), .disc_in(disc_in), .ext_trig(ext_trig), .cell_ptr(cell_ptr),
    .ts_gray(ts_gray), .conv_free(conv_free), .sample_run(sample_run),
    .conv_req(conv_req), .cap_cell(cap_cell), .cap_ts(cap_ts),
    .central_trig(central_trig)
  );

  function automatic logic [5:0] mk(input bit en, input bit fall, input int src, input int post);
    return {2'(post), 2'(src), fall, en};
  endfunction

  function automatic int eff(input int p);
    return (p == 3) ? 2 : p;
  endfunction

  function automatic int gray_of(input int unsigned v);
    int unsigned b;
    b = v & 32'hFFF;
    return int'(b ^ (b >> 1));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input logic [5:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(ch); cfg_data = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic release_ch(input int ch);
    conv_free[ch] = 1'b1;
    @(negedge clk);
    conv_free[ch] = 1'b0;
    check("R10 run after release", int'(sample_run[ch]), 1);
    check("R10 req cleared", int'(conv_req[ch]), 0);
  endtask

  task automatic trial(input int ch, input bit fall, input int post);
    int unsigned c;
    int d;
    d = eff(post);
    disc_in[ch] = fall;
    cfg(ch, mk(1'b1, fall, 0, post));          // R2 mode write
    c = tb_cnt;
    disc_in[ch] = ~fall;
    for (int j = 0; j < d; j++) begin
      @(negedge clk);
      check("R8 still sampling in delay", int'(sample_run[ch]), 1);
    end
    @(negedge clk);
    check("R3 fired on selected edge", int'(conv_req[ch]), 1);
    check("R8 captured cell", int'(cap_cell[ch*6 +: 6]), int'((c + d) & 63));
    check("R8 captured timestamp", int'(cap_ts[ch*12 +: 12]), gray_of(c + d));
    disc_in[ch] = fall;
    @(negedge clk);
    disc_in[ch] = ~fall;
    @(negedge clk);
    check("R9 held ignores triggers", int'(conv_req[ch]), 1);
    check("R9 capture stable", int'(cap_cell[ch*6 +: 6]), int'((c + d) & 63));
    disc_in[ch] = fall;
    release_ch(ch);
    cfg(ch, 6'd0);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    int unsigned c;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 all sampling", int'(sample_run), 16'hFFFF);
    check("R1 no request", int'(conv_req), 0);
    check("R1 central low", int'(central_trig), 0);
    disc_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 default mode disabled", int'(conv_req[0]), 0);
    disc_in[0] = 1'b0;

    // R6 disabled channel (source local, enable 0)
    cfg(7, mk(1'b0, 1'b0, 0, 0));
    disc_in[7] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 disabled no fire", int'(conv_req[7]), 0);
    disc_in[7] = 1'b0;

    // R7 global enable low, then R3 wrong edge, then proper edge
    glob_en = 1'b0;
    cfg(4, mk(1'b1, 1'b0, 0, 0));
    disc_in[4] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 no fire when global off", int'(conv_req[4]), 0);
    glob_en = 1'b1;
    disc_in[4] = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3 opposite edge ignored", int'(conv_req[4]), 0);
    c = tb_cnt;
    disc_in[4] = 1'b1;
    @(negedge clk);
    check("R3 rising fires", int'(conv_req[4]), 1);
    check("R3 capture cell", int'(cap_cell[4*6 +: 6]), int'(c & 63));
    disc_in[4] = 1'b0;
    release_ch(4);
    cfg(4, 6'd0);

    // R4 external, delay 1
    cfg(5, mk(1'b1, 1'b0, 1, 1));
    c = tb_cnt;
    ext_trig = 1'b1;
    @(negedge clk);
    check("R4 delay step sampling", int'(sample_run[5]), 1);
    @(negedge clk);
    check("R4 external fired", int'(conv_req[5]), 1);
    check("R4 capture cell", int'(cap_cell[5*6 +: 6]), int'((c + 1) & 63));
    ext_trig = 1'b0;
    release_ch(5);
    cfg(5, 6'd0);

    // R11 source none
    cfg(11, mk(1'b1, 1'b0, 3, 0));
    disc_in[11] = 1'b1; ext_trig = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 source none no fire", int'(conv_req[11]), 0);
    disc_in[11] = 1'b0; ext_trig = 1'b0;
    cfg(11, 6'd0);

    // R5 central
    cfg(2, mk(1'b1, 1'b0, 0, 0));
    cfg(9, mk(1'b1, 1'b1, 2, 0));
    c = tb_cnt;
    disc_in[2] = 1'b1;
    @(negedge clk);
    check("R5 central reg out", int'(central_trig), 1);
    check("R5 local source fired", int'(conv_req[2]), 1);
    check("R5 central source fired", int'(conv_req[9]), 1);
    check("R5 central capture", int'(cap_cell[9*6 +: 6]), int'(c & 63));
    @(negedge clk);
    check("R5 central one cycle", int'(central_trig), 0);
    release_ch(2);
    release_ch(9);
    cfg(2, mk(1'b0, 1'b0, 0, 0));
    disc_in[2] = 1'b0;
    @(negedge clk);
    disc_in[2] = 1'b1;
    @(negedge clk);
    check("R5 disabled channel not in OR", int'(central_trig), 0);
    @(negedge clk);
    check("R5 central channel idle", int'(conv_req[9]), 0);
    cfg(9, 6'd0);
    disc_in[2] = 1'b0;
    @(negedge clk);

    // random trials, R2 R3 R8 R9 R10
    for (int t = 0; t < 40; t++) begin
      int ch;
      ch = int'($urandom % 16);
      trial(ch, 1'($urandom % 2), int'($urandom % 4));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule